// File: doc/BRIEF.md
# Single-Slot Probe Mailbox

This block passes messages from one producer to one consumer through a storage slot that holds one message. A flag, called the probe here, records whether the slot holds a message the consumer has not yet taken. Each side starts an operation with a one-cycle start pulse and learns that the operation has finished from a one-cycle done pulse. The block accepts and holds a request until it can complete it. A write completes only into an empty slot. A read completes only from a full slot. If the other side is not ready, the pending request polls the probe again on every clock.

The writer captures its data word together with the start pulse and may change the data bus afterwards. The reader finds the message on a registered output that keeps its value until the next read completes. When the `HAS_DATA` parameter is zero, the block has no data storage. The same handshake then carries only an event, and the read data output is held at zero.

Top module: `probe_mailbox`

## Requirements
- R1: After reset the probe is clear, `send_done` and `recv_done` are low, and `recv_data` is zero.
- R2: A `send_start` sampled while the slot is empty produces a `send_done` pulse that is high in the second cycle after the start cycle. The probe is then set.
- R3: A send requested while the slot is full produces no `send_done` until a read empties the slot. Its `send_done` then rises exactly one cycle after that read's `recv_done`, because the probe clear takes effect before the waiting send can set the probe again.
- R4: A receive requested while the slot is empty produces no `recv_done` until a send fills the slot. Its `recv_done` then rises exactly one cycle after that send's `send_done`.
- R5: A `recv_start` sampled while the slot is full produces a `recv_done` pulse that is high in the second cycle after the start cycle, with the buffered message on `recv_data` in that same cycle.
- R6: `recv_data` keeps its value from one completed receive until the next completed receive.
- R7: Messages arrive in the order they were sent, and each message is delivered exactly once.
- R8: The message stored is the value of `send_data` in the `send_start` cycle. Later changes to `send_data` have no effect.
- R9: With `HAS_DATA` = 0, the handshake timing is identical to the data variant and `recv_data` stays zero.
- R10: `send_done` and `recv_done` are each high for exactly one cycle per completed operation.
- R11: A start pulse on a side whose earlier request is still pending is ignored. It produces no extra done pulse and no extra message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| send_start | input | 1 | One-cycle pulse that requests a write |
| send_data | input | WIDTH | Message, sampled with `send_start` |
| send_done | output | 1 | One-cycle pulse when the write has completed |
| recv_start | input | 1 | One-cycle pulse that requests a read |
| recv_data | output | WIDTH | Last received message (zero in the signal variant) |
| recv_done | output | 1 | One-cycle pulse when the read has completed |

## Verification
The bench builds one copy with `WIDTH` = 8 and `HAS_DATA` = 1, and a second copy with `HAS_DATA` = 0. Both copies are driven from the same stimulus, so every handshake cycle count can be compared directly between the data variant and the signal variant. An 8-bit message makes it possible to stream a long sequence of distinct, arithmetically generated values under random delays on both sides, which exercises every combination of idle, waiting and back-to-back requests. Directed steps then pin down the exact cycle of each done pulse around a full slot and an empty slot.

// File: rtl/probe_mailbox_pkg.sv
package probe_mailbox_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic holdLoad;   // capture the writer's word
    logic bufLoad;    // move the held word into the slot
    logic outLoad;    // copy the slot to the reader output
    logic probeSet;   // mark the slot full
    logic probeClr;   // mark the slot empty
  } mboxStrobes_t;

endpackage

// File: rtl/probe_mailbox_ctrl.sv
module probe_mailbox_ctrl
  import probe_mailbox_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sendStart,
  input  logic         recvStart,
  input  logic         probe,
  output mboxStrobes_t strobes,
  output logic         sendDone,
  output logic         recvDone
);

  logic sendPend, recvPend;
  logic commitSend, commitRecv;

  // A pending request commits only when the probe allows it. Both commits
  // can never be true together, so a clear always lands before a new set.
  assign commitSend = sendPend && !probe;
  assign commitRecv = recvPend && probe;

  always_comb begin
    strobes          = '0;
    strobes.holdLoad = sendStart && !sendPend;
    strobes.bufLoad  = commitSend;
    strobes.probeSet = commitSend;
    strobes.outLoad  = commitRecv;
    strobes.probeClr = commitRecv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sendPend <= 1'b0;
      recvPend <= 1'b0;
      sendDone <= 1'b0;
      recvDone <= 1'b0;
    end else begin
      if (commitSend)     sendPend <= 1'b0;
      else if (sendStart) sendPend <= 1'b1;
      if (commitRecv)     recvPend <= 1'b0;
      else if (recvStart) recvPend <= 1'b1;
      sendDone <= commitSend;
      recvDone <= commitRecv;
    end
  end

  assert_send_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sendDone |=> !sendDone);
  assert_recv_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recvDone |=> !recvDone);
  assert_send_done_sets_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sendDone |-> probe || recvDone);
  assert_recv_done_clears_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recvDone |-> !probe || sendDone);

endmodule

// File: rtl/probe_mailbox_dp.sv
module probe_mailbox_dp
  import probe_mailbox_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mboxStrobes_t     strobes,
  input  logic [WIDTH-1:0] sendData,
  output logic [WIDTH-1:0] recvData,
  output logic             probe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                probe <= 1'b0;
    else if (strobes.probeClr) probe <= 1'b0;
    else if (strobes.probeSet) probe <= 1'b1;
  end

  assert_set_only_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.probeSet |-> !probe);
  assert_clr_only_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.probeClr |-> probe);
  assert_set_takes_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.probeSet |=> probe);
  assert_clr_takes_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.probeClr |=> !probe);

  generate
    if (HAS_DATA) begin : gData
      logic [WIDTH-1:0] holdQ, slotQ, outQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          holdQ <= '0;
          slotQ <= '0;
          outQ  <= '0;
        end else begin
          if (strobes.holdLoad) holdQ <= sendData;
          if (strobes.bufLoad)  slotQ <= holdQ;
          if (strobes.outLoad)  outQ  <= slotQ;
        end
      end
      assign recvData = outQ;

      assert_slot_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !strobes.bufLoad |=> $stable(slotQ));
      assert_output_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobes.outLoad |=> $stable(recvData));
    end else begin : gSignal
      logic unusedInputs;
      assign unusedInputs = ^{sendData, strobes.holdLoad, strobes.bufLoad, strobes.outLoad};
      assign recvData = '0;

      assert_signal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recvData == '0);
    end
  endgenerate

endmodule

// File: rtl/probe_mailbox.sv
module probe_mailbox
  import probe_mailbox_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_start,
  input  logic [WIDTH-1:0] send_data,
  output logic             send_done,
  input  logic             recv_start,
  output logic [WIDTH-1:0] recv_data,
  output logic             recv_done
);

  mboxStrobes_t strobes;
  logic         probe;

  probe_mailbox_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sendStart (send_start),
    .recvStart (recv_start),
    .probe     (probe),
    .strobes   (strobes),
    .sendDone  (send_done),
    .recvDone  (recv_done)
  );

  probe_mailbox_dp #(.WIDTH(WIDTH), .HAS_DATA(HAS_DATA)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .sendData (send_data),
    .recvData (recv_data),
    .probe    (probe)
  );

endmodule

// File: tb/probe_mailbox_test.sv
`timescale 1ns/1ps
module probe_mailbox_test;

  localparam int W = 8;
  localparam int NSTREAM = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send_start = 1'b0;
  logic recv_start = 1'b0;
  logic [W-1:0] send_data = '0;
  logic send_done, recv_done, sigSendDone, sigRecvDone;
  logic [W-1:0] recv_data, sigRecvData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  probe_mailbox #(.WIDTH(W), .HAS_DATA(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .send_start(send_start), .send_data(send_data),
    .send_done(send_done), .recv_start(recv_start), .recv_data(recv_data),
    .recv_done(recv_done));

  probe_mailbox #(.WIDTH(W), .HAS_DATA(1'b0)) uutSig (
    .clk(clk), .rst_n(rst_n), .send_start(send_start), .send_data(send_data),
    .send_done(sigSendDone), .recv_start(recv_start), .recv_data(sigRecvData),
    .recv_done(sigRecvDone));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Check both done outputs of both variants against expected levels (R9).
  task automatic chkDone(input string req, input bit expSend, input bit expRecv);
    chk(send_done == expSend, {req, " send_done"}, send_done, expSend);
    chk(recv_done == expRecv, {req, " recv_done"}, recv_done, expRecv);
    chk(sigSendDone == expSend && sigRecvDone == expRecv, "R9 signal variant handshake",
        {sigSendDone, sigRecvDone}, {expSend, expRecv});
    chk(sigRecvData == '0, "R9 signal data zero", sigRecvData, 0);
  endtask

  // Called at a negedge; returns one negedge later with the data bus scrambled (R8).
  task automatic pulseSend(input logic [W-1:0] d);
    send_start = 1'b1;
    send_data  = d;
    @(negedge clk);
    send_start = 1'b0;
    send_data  = ~d;
  endtask

  task automatic pulseRecv();
    recv_start = 1'b1;
    @(negedge clk);
    recv_start = 1'b0;
  endtask

  function automatic logic [W-1:0] streamVal(input int i);
    return W'((i * 53 + 17) & 8'hFF);
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(recv_data == '0, "R1 recv_data", recv_data, 0);
    chkDone("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chkDone("R1", 1'b0, 1'b0);

    // R2, R8, R10: send into an empty slot
    pulseSend(8'h5A);
    chkDone("R2 not yet", 1'b0, 1'b0);
    @(negedge clk);
    chkDone("R2", 1'b1, 1'b0);
    @(negedge clk);
    chkDone("R10 send pulse width", 1'b0, 1'b0);

    // R3, R11: send into a full slot waits; an extra start is ignored
    pulseSend(8'hC3);
    pulseSend(8'h99);
    for (int k = 0; k < 6; k++) begin
      chkDone("R3 waiting", 1'b0, 1'b0);
      @(negedge clk);
    end

    // R5 and R3: the read empties the slot, the waiting send lands one cycle later
    pulseRecv();
    chkDone("R5 not yet", 1'b0, 1'b0);
    @(negedge clk);
    chkDone("R5", 1'b0, 1'b1);
    chk(recv_data == 8'h5A, "R5/R8 data", recv_data, 8'h5A);
    @(negedge clk);
    chkDone("R3", 1'b1, 1'b0);
    @(negedge clk);
    chkDone("R10", 1'b0, 1'b0);

    // R5, R7: the second message
    pulseRecv();
    @(negedge clk);
    chkDone("R5 second", 1'b0, 1'b1);
    chk(recv_data == 8'hC3, "R7 order", recv_data, 8'hC3);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(recv_data == 8'hC3, "R6 hold", recv_data, 8'hC3);
    end

    // R4, R11: a read on an empty slot waits, and the ignored start left no message
    pulseRecv();
    for (int k = 0; k < 6; k++) begin
      chkDone("R4/R11 waiting", 1'b0, 1'b0);
      chk(recv_data == 8'hC3, "R6 hold while waiting", recv_data, 8'hC3);
      @(negedge clk);
    end
    pulseSend(8'h3C);
    @(negedge clk);
    chkDone("R4 send", 1'b1, 1'b0);
    @(negedge clk);
    chkDone("R4", 1'b0, 1'b1);
    chk(recv_data == 8'h3C, "R4 data", recv_data, 8'h3C);
    @(negedge clk);

    // R7: stream with random delays on both sides
    fork
      begin
        for (int i = 0; i < NSTREAM; i++) begin
          repeat ($urandom % 4) @(negedge clk);
          pulseSend(streamVal(i));
          do @(negedge clk); while (!send_done);
        end
      end
      begin
        for (int i = 0; i < NSTREAM; i++) begin
          repeat ($urandom % 4) @(negedge clk);
          pulseRecv();
          do @(negedge clk); while (!recv_done);
          chk(recv_data == streamVal(i), "R7 stream order", recv_data, streamVal(i));
          chk(sigRecvDone == 1'b1, "R9 stream handshake", sigRecvDone, 1);
        end
      end
    join
    repeat (4) @(negedge clk);
    chkDone("R7 drained", 1'b0, 1'b0);
    finish();
  end

endmodule